// File: doc/BRIEF.md
# Descriptor Ring Receive DMA Channel

This block is a scatter-gather DMA channel. It walks a ring of buffer descriptors kept in a synchronous word-addressed memory. It moves words arriving on a valid/ready stream into the buffers those descriptors name. Each descriptor holds five 32-bit words:

| Word offset | Content |
|---|---|
| +0 | Link to the next descriptor |
| +1 | Buffer address |
| +2 | Buffer length in words |
| +3 | Status/control |
| +4 | Received word count, written back by the engine |

The last link in the ring points back to the first descriptor.

Software uses a small register port. It loads the current-descriptor pointer, then writes the tail pointer to hand work to the engine. The engine processes descriptors from the current one up to and including the tail, then stops. A frame longer than one buffer spills into the following descriptors. Each finished descriptor gets completion, start-of-frame and end-of-frame flags in its status word.

Completions of descriptors flagged for interrupt are coalesced by count and by an idle delay into an interrupt status register that software clears by writing ones. Fetching a descriptor that is already marked complete halts the channel with an error. A soft reset clears the engine.

Register map (word index on `reg_addr_i`):

| Index | Register |
|---|---|
| 0 | Control (bit 0 = soft reset) |
| 1 | Current pointer |
| 2 | Tail pointer |
| 3 | Interrupt status |
| 4 | Coalesce threshold |
| 5 | Delay cycles |

Top module: `ringdma_channel`

## Requirements
- R1: After rst_ni is released, the registers read as follows: control 0, current 0, tail 0, interrupt status 0, coalesce threshold 1, delay 0. In this state s_ready_o, irq_o and mem_req_o are low.
- R2: For each descriptor, the engine reads words +0 to +3 at the current pointer. It then stores stream words in arrival order at buffer address + 0, +1, and so on, and never stores more words than the buffer length (low 14 bits of word +2).
- R3: When the buffer fills before the word flagged s_last_i arrives, the frame continues in the descriptor named by the link word. The walk follows the links around the ring, including the wrap from the last descriptor to the first.
- R4: On finishing a descriptor, the engine writes the number of words it stored into the low 14 bits of word +4. It then rewrites word +3 with these changes: bit 31 (complete) set; bit 27 (start of frame) set when the descriptor holds the first word of a frame; bit 26 (end of frame) set when it holds the last word; all other bits, including bit 24 (interrupt on end), unchanged.
- R5: A write to the tail register arms the engine. The engine stops after finishing the descriptor whose address equals the tail. At that point the current register reads that descriptor's link word, and the engine neither fetches nor accepts stream data until the tail is written again.
- R6: Each finished descriptor with bit 24 set counts one event. When the count reaches the coalesce threshold (register 4; 0 acts as 1), interrupt status bit 0 is set and the count restarts.
- R7: While the event count is non-zero and the delay register is non-zero, the delay register's number of cycles without a new event sets interrupt status bit 1 and clears the count. A delay value of 0 disables this.
- R8: Fetching a descriptor whose bit 31 is already set sets interrupt status bit 7 and leaves the descriptor unwritten. The channel then stays halted, even through later tail writes, until a soft reset.
- R9: Writing the interrupt status register clears exactly the bits written as 1. irq_o is high while any status bit is set.
- R10: Writing 1 to control bit 0 starts a soft reset. Control bit 0 then reads 1 for 4 cycles (RST_CYCLES) and afterwards 0. Register writes are ignored in that window. All registers return to their R1 values, and no memory or stream activity occurs during the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after a read request |
| s_valid_i | input | 1 | Stream word valid |
| s_data_i | input | 32 | Stream word |
| s_last_i | input | 1 | Stream word ends the frame |
| s_ready_o | output | 1 | Engine accepts the stream word |
| irq_o | output | 1 | Interrupt, OR of the status bits |

## Verification
The hardest situations to reach are frames that end exactly on a buffer boundary and walks that run across the ring wrap. Both depend on the exact pairing of frame length and buffer size. The bench sweeps every frame length from one word up to four full buffers, for buffer sizes of two, three and four words. The ring is linked in a permuted order, so a walk that ignored the link word would land on the wrong descriptor. The halt-on-error path is reached by planting a descriptor that is already marked complete while a stream word waits at the input.

// File: rtl/ringdma_pkg.sv
package ringdma_pkg;
  localparam int FETCH_WORDS = 4;
  localparam int OFS_NEXT    = 0;
  localparam int OFS_BUF     = 1;
  localparam int OFS_LEN     = 2;
  localparam int OFS_STS     = 3;
  localparam int OFS_RXLEN   = 4;

  localparam int ST_CMPLT = 31;
  localparam int ST_SOP   = 27;
  localparam int ST_EOP   = 26;
  localparam int ST_IOE   = 24;

  localparam int IRQ_W    = 8;
  localparam int IRQ_COAL = 0;
  localparam int IRQ_DLY  = 1;
  localparam int IRQ_ERR  = 7;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_CUR  = 3'd1;
  localparam logic [2:0] REG_TAIL = 3'd2;
  localparam logic [2:0] REG_IRQ  = 3'd3;
  localparam logic [2:0] REG_COAL = 3'd4;
  localparam logic [2:0] REG_DLY  = 3'd5;

  typedef logic [31:0] word_t;

  typedef enum logic [2:0] {
    W_IDLE, W_FETCH, W_CHECK, W_XFER, W_WB_LEN, W_WB_STS
  } walk_state_e;
endpackage

// File: rtl/ringdma_walker.sv
module ringdma_walker
  import ringdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] tail_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output word_t             mem_wdata_o,
  input  word_t             mem_rdata_i,
  input  logic              s_valid_i,
  input  word_t             s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              idle_o,
  output logic              adv_o,
  output logic [ADDR_W-1:0] next_o,
  output logic              tail_hit_o,
  output logic              evt_o,
  output logic              err_o
);
  localparam int IDX_W = $clog2(FETCH_WORDS + 1);

  walk_state_e       state_q;
  logic [IDX_W-1:0]  fidx_q, rd_idx_q;
  logic              rd_vld_q;
  logic [ADDR_W-1:0] next_q, buf_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  word_t             sts_q;
  logic              eop_q, in_frame_q;
  logic              take, buf_full, fetch_issue;

  assign fetch_issue = (state_q == W_FETCH) && (fidx_q < IDX_W'(FETCH_WORDS));
  assign buf_full    = cnt_q >= len_q;
  assign s_ready_o   = (state_q == W_XFER) && !buf_full;
  assign take        = s_ready_o && s_valid_i;
  assign idle_o      = state_q == W_IDLE;
  assign next_o      = next_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    adv_o       = 1'b0;
    tail_hit_o  = 1'b0;
    evt_o       = 1'b0;
    err_o       = 1'b0;
    unique case (state_q)
      W_FETCH: if (fetch_issue) begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_i + ADDR_W'(fidx_q);
      end
      W_CHECK: err_o = sts_q[ST_CMPLT];
      W_XFER: if (take) begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = buf_q + ADDR_W'(cnt_q);
        mem_wdata_o = s_data_i;
      end
      W_WB_LEN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_i + ADDR_W'(OFS_RXLEN);
        mem_wdata_o = word_t'(cnt_q);
      end
      W_WB_STS: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_i + ADDR_W'(OFS_STS);
        mem_wdata_o = sts_q;
        mem_wdata_o[ST_CMPLT] = 1'b1;
        if (!in_frame_q) mem_wdata_o[ST_SOP] = 1'b1;
        if (eop_q)       mem_wdata_o[ST_EOP] = 1'b1;
        adv_o      = 1'b1;
        tail_hit_o = cur_i == tail_i;
        evt_o      = sts_q[ST_IOE];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= W_IDLE;
      fidx_q     <= '0;
      rd_idx_q   <= '0;
      rd_vld_q   <= 1'b0;
      next_q     <= '0;
      buf_q      <= '0;
      len_q      <= '0;
      sts_q      <= '0;
      cnt_q      <= '0;
      eop_q      <= 1'b0;
      in_frame_q <= 1'b0;
    end else if (clr_i) begin
      state_q    <= W_IDLE;
      fidx_q     <= '0;
      rd_vld_q   <= 1'b0;
      cnt_q      <= '0;
      eop_q      <= 1'b0;
      in_frame_q <= 1'b0;
    end else begin
      rd_vld_q <= fetch_issue;
      rd_idx_q <= fidx_q;
      if (rd_vld_q) begin
        unique case (int'(rd_idx_q))
          OFS_NEXT: next_q <= mem_rdata_i[ADDR_W-1:0];
          OFS_BUF:  buf_q  <= mem_rdata_i[ADDR_W-1:0];
          OFS_LEN:  len_q  <= mem_rdata_i[LEN_W-1:0];
          default:  sts_q  <= mem_rdata_i;
        endcase
      end
      unique case (state_q)
        W_IDLE: if (start_i) begin
          state_q <= W_FETCH;
          fidx_q  <= '0;
        end
        W_FETCH: begin
          if (fetch_issue) fidx_q <= fidx_q + 1'b1;
          if (rd_vld_q && int'(rd_idx_q) == OFS_STS) state_q <= W_CHECK;
        end
        W_CHECK: begin
          cnt_q   <= '0;
          state_q <= sts_q[ST_CMPLT] ? W_IDLE : W_XFER;
        end
        W_XFER: begin
          if (buf_full) begin
            eop_q   <= 1'b0;
            state_q <= W_WB_LEN;
          end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
            if (s_last_i || (cnt_q + LEN_W'(1)) == len_q) begin
              eop_q   <= s_last_i;
              state_q <= W_WB_LEN;
            end
          end
        end
        W_WB_LEN: state_q <= W_WB_STS;
        W_WB_STS: begin
          in_frame_q <= !eop_q;
          state_q    <= W_IDLE;
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  // R2: buffer writes stay inside [buf, buf+len)
  a_r2_in_buffer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == W_XFER && mem_we_o) |-> ((mem_addr_o - buf_q) < ADDR_W'(len_q)));

endmodule

// File: rtl/ringdma_irq.sv
module ringdma_irq
  import ringdma_pkg::*;
#(
  parameter int COAL_W = 8,
  parameter int DLY_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              evt_i,
  input  logic              err_i,
  input  logic [COAL_W-1:0] coal_max_i,
  input  logic [DLY_W-1:0]  dly_max_i,
  input  logic              ack_i,
  input  logic [IRQ_W-1:0]  ack_mask_i,
  output logic [IRQ_W-1:0]  sts_o
);
  logic [COAL_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0]  tmr_q, tmr_d;
  logic [IRQ_W-1:0]  sts_q, sts_d;
  logic [COAL_W:0]   cnt_inc;
  logic              set_coal, set_dly;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    set_coal = 1'b0;
    set_dly  = 1'b0;
    cnt_d    = cnt_q;
    tmr_d    = tmr_q;
    if (evt_i) begin
      tmr_d = '0;
      if (cnt_inc >= {1'b0, coal_max_i}) begin
        set_coal = 1'b1;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_inc[COAL_W-1:0];
      end
    end else if (cnt_q != '0 && dly_max_i != '0) begin
      tmr_d = tmr_q + 1'b1;
      if (tmr_d == dly_max_i) begin
        set_dly = 1'b1;
        cnt_d   = '0;
        tmr_d   = '0;
      end
    end
    sts_d = sts_q & ~(ack_i ? ack_mask_i : '0);
    if (set_coal) sts_d[IRQ_COAL] = 1'b1;
    if (set_dly)  sts_d[IRQ_DLY]  = 1'b1;
    if (err_i)    sts_d[IRQ_ERR]  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmr_q <= '0;
      sts_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      tmr_q <= '0;
      sts_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      tmr_q <= tmr_d;
      sts_q <= sts_d;
    end
  end

  assign sts_o = sts_q;

  // R6: a coalesce interrupt restarts the event count
  a_r6_coal_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[IRQ_COAL]) |-> cnt_q == '0);
  // R7: delay interrupt only with pending events
  a_r7_dly_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[IRQ_DLY]) |-> $past(cnt_q) != '0);

endmodule

// File: rtl/ringdma_channel.sv
module ringdma_channel
  import ringdma_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 14,
  parameter int COAL_W     = 8,
  parameter int DLY_W      = 16,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              s_valid_i,
  input  logic [31:0]       s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              irq_o
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [RC_W-1:0]   rst_cnt_q;
  logic [ADDR_W-1:0] cur_q, tail_q;
  logic [COAL_W-1:0] coal_q;
  logic [DLY_W-1:0]  dly_q;
  logic              run_q, halted_q;
  logic              busy, wr, soft_go, clr;
  logic              w_idle, w_adv, w_tail_hit, w_evt, w_err;
  logic [ADDR_W-1:0] w_next;
  logic [IRQ_W-1:0]  irq_sts;

  assign busy    = rst_cnt_q != '0;
  assign wr      = reg_we_i && !busy;
  assign soft_go = wr && reg_addr_i == REG_CTRL && reg_wdata_i[0];
  assign clr     = soft_go || busy;

  ringdma_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walk (
    .clk_i, .rst_ni,
    .clr_i      (clr),
    .start_i    (run_q && !halted_q && !clr),
    .cur_i      (cur_q),
    .tail_i     (tail_q),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .s_valid_i, .s_data_i, .s_last_i, .s_ready_o,
    .idle_o     (w_idle),
    .adv_o      (w_adv),
    .next_o     (w_next),
    .tail_hit_o (w_tail_hit),
    .evt_o      (w_evt),
    .err_o      (w_err)
  );

  ringdma_irq #(.COAL_W(COAL_W), .DLY_W(DLY_W)) u_irq (
    .clk_i, .rst_ni,
    .clr_i      (clr),
    .evt_i      (w_evt),
    .err_i      (w_err),
    .coal_max_i (coal_q),
    .dly_max_i  (dly_q),
    .ack_i      (wr && reg_addr_i == REG_IRQ),
    .ack_mask_i (reg_wdata_i[IRQ_W-1:0]),
    .sts_o      (irq_sts)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_cnt_q <= '0;
      cur_q     <= '0;
      tail_q    <= '0;
      run_q     <= 1'b0;
      halted_q  <= 1'b0;
      coal_q    <= COAL_W'(1);
      dly_q     <= '0;
    end else if (soft_go) begin
      rst_cnt_q <= RC_W'(RST_CYCLES);
      cur_q     <= '0;
      tail_q    <= '0;
      run_q     <= 1'b0;
      halted_q  <= 1'b0;
      coal_q    <= COAL_W'(1);
      dly_q     <= '0;
    end else if (busy) begin
      rst_cnt_q <= rst_cnt_q - 1'b1;
    end else begin
      if (w_adv)
        cur_q <= w_next;
      else if (wr && reg_addr_i == REG_CUR && w_idle)
        cur_q <= reg_wdata_i[ADDR_W-1:0];
      if (wr && reg_addr_i == REG_TAIL) begin
        tail_q <= reg_wdata_i[ADDR_W-1:0];
        run_q  <= 1'b1;
      end else if (w_tail_hit) begin
        run_q <= 1'b0;
      end
      if (w_err) halted_q <= 1'b1;
      if (wr && reg_addr_i == REG_COAL) coal_q <= reg_wdata_i[COAL_W-1:0];
      if (wr && reg_addr_i == REG_DLY)  dly_q  <= reg_wdata_i[DLY_W-1:0];
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      REG_CTRL: reg_rdata_o = {31'd0, busy};
      REG_CUR:  reg_rdata_o = 32'(cur_q);
      REG_TAIL: reg_rdata_o = 32'(tail_q);
      REG_IRQ:  reg_rdata_o = 32'(irq_sts);
      REG_COAL: reg_rdata_o = 32'(coal_q);
      REG_DLY:  reg_rdata_o = 32'(dly_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |irq_sts;

  // R5: finishing the tail descriptor disarms the engine
  a_r5_stop_at_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_tail_hit && !clr && !(wr && reg_addr_i == REG_TAIL)) |=> !run_q);
  // R8: a halted channel touches no memory
  a_r8_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |-> !mem_req_o);
  // R10: no traffic while the soft reset runs
  a_r10_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (!mem_req_o && !s_ready_o));

endmodule

// File: tb/ringdma_channel_test.sv
module ringdma_channel_test;
  localparam int ADDR_W = 16;
  localparam logic [31:0] CMPLT = 32'h8000_0000;
  localparam logic [31:0] SOP   = 32'h0800_0000;
  localparam logic [31:0] EOP   = 32'h0400_0000;
  localparam logic [31:0] IOE   = 32'h0100_0000;
  localparam logic [31:0] MARK  = 32'h0000_DEAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic s_last = 1'b0;
  logic s_ready, irq;

  logic [31:0] mem [0:255];
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  ringdma_channel #(.ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_last_i(s_last), .s_ready_o(s_ready),
    .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic soft_reset();
    reg_wr(3'd0, 32'd1);
    repeat (8) @(negedge clk);
  endtask

  function automatic int daddr(input int k);
    // ring walk order 0x00 -> 0x10 -> 0x08 -> 0x18 -> 0x00
    case (k % 4)
      1: return 16;
      2: return 8;
      3: return 24;
      default: return 0;
    endcase
  endfunction

  function automatic int baddr(input int k);
    return 64 + 16 * k;
  endfunction

  function automatic logic [31:0] pat(input int it, input int k);
    return 32'hA500_0000 | (it << 8) | k;
  endfunction

  task automatic setup_ring(input int len);
    for (int w = 0; w < 4; w++) begin
      mem[daddr(w)]     = daddr(w + 1);
      mem[daddr(w) + 1] = baddr(w);
      mem[daddr(w) + 2] = len;
      mem[daddr(w) + 3] = IOE;
      mem[daddr(w) + 4] = MARK;
    end
    for (int a = 64; a < 128; a++) mem[a] = '0;
  endtask

  task automatic push_frame(input int it, input int nw);
    for (int k = 0; k < nw; k++) begin
      bit ok;
      int guard;
      s_valid = 1'b1; s_data = pat(it, k); s_last = (k == nw - 1);
      ok = 1'b0; guard = 0;
      while (!ok && guard < 500) begin
        ok = s_ready;
        guard++;
        @(negedge clk);
      end
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int it;
    for (int a = 0; a < 256; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_rd(3'd0, rd); check("R1 ctrl", rd, 0);
    reg_rd(3'd1, rd); check("R1 cur", rd, 0);
    reg_rd(3'd2, rd); check("R1 tail", rd, 0);
    reg_rd(3'd3, rd); check("R1 irq", rd, 0);
    reg_rd(3'd4, rd); check("R1 coal", rd, 1);
    reg_rd(3'd5, rd); check("R1 dly", rd, 0);
    check("R1 outputs", {29'd0, s_ready, irq, mem_req}, 0);

    // R2 R3 R4 R5 R6 R9: sweep frame length against buffer size
    it = 0;
    for (int L = 2; L <= 4; L++) begin
      for (int F = 1; F <= 4 * L; F++) begin
        int n;
        n = (F + L - 1) / L;
        soft_reset();
        setup_ring(L);
        reg_wr(3'd1, 32'd0);
        reg_wr(3'd2, daddr(n - 1));
        push_frame(it, F);
        repeat (30) @(negedge clk);
        for (int w = 0; w < 4; w++) begin
          if (w < n) begin
            int words;
            logic [31:0] es;
            words = (w < n - 1) ? L : F - (n - 1) * L;
            es = IOE | CMPLT | ((w == 0) ? SOP : 0) | ((w == n - 1) ? EOP : 0);
            check("R4 status", mem[daddr(w) + 3], es);
            check("R4 count", mem[daddr(w) + 4], words);
            for (int j = 0; j < L; j++)
              check((j < words) ? "R2 R3 data" : "R2 no overrun",
                    mem[baddr(w) + j], (j < words) ? pat(it, w * L + j) : 0);
          end else begin
            check("R5 untouched status", mem[daddr(w) + 3], IOE);
            check("R5 untouched count", mem[daddr(w) + 4], MARK);
          end
        end
        reg_rd(3'd1, rd); check("R5 R3 cur after stop", rd, daddr(n));
        check("R5 stream held", {31'd0, s_ready}, 0);
        reg_rd(3'd3, rd); check("R6 coal default", rd, 1);
        check("R9 irq out", {31'd0, irq}, 1);
        reg_wr(3'd3, 32'd1);
        reg_rd(3'd3, rd); check("R9 cleared", rd, 0);
        check("R9 irq low", {31'd0, irq}, 0);
        it++;
      end
    end

    // R6 coalesce threshold 3
    soft_reset();
    setup_ring(4);
    reg_wr(3'd4, 32'd3);
    for (int k = 0; k < 3; k++) begin
      reg_wr(3'd2, daddr(k));
      push_frame(100 + k, 1);
      repeat (20) @(negedge clk);
      reg_rd(3'd3, rd);
      check("R6 coalesce count", rd, (k < 2) ? 0 : 1);
    end

    // R7 delay interrupt, R9 partial clear
    soft_reset();
    setup_ring(4);
    reg_wr(3'd4, 32'd4);
    reg_wr(3'd5, 32'd20);
    reg_wr(3'd2, daddr(0));
    push_frame(110, 1);
    repeat (8) @(negedge clk);
    reg_rd(3'd3, rd); check("R7 not yet", rd, 0);
    repeat (40) @(negedge clk);
    reg_rd(3'd3, rd); check("R7 delay fired", rd, 2);
    check("R9 irq with delay", {31'd0, irq}, 1);
    reg_wr(3'd3, 32'd1);
    reg_rd(3'd3, rd); check("R9 other bit kept", rd, 2);
    reg_wr(3'd3, 32'd2);
    reg_rd(3'd3, rd); check("R9 bit cleared", rd, 0);

    // R8 error halt, R10 soft reset
    soft_reset();
    setup_ring(4);
    mem[daddr(0) + 3] = CMPLT | IOE;
    reg_wr(3'd2, daddr(0));
    s_valid = 1'b1; s_data = 32'h1234_5678; s_last = 1'b1;
    begin
      bit saw;
      saw = 1'b0;
      repeat (30) begin @(negedge clk); if (s_ready) saw = 1'b1; end
      check("R8 no accept", {31'd0, saw}, 0);
      reg_rd(3'd3, rd); check("R8 error bit", rd, 32'h80);
      check("R8 desc status kept", mem[daddr(0) + 3], CMPLT | IOE);
      check("R8 desc count kept", mem[daddr(0) + 4], MARK);
      reg_rd(3'd1, rd); check("R8 cur held", rd, 0);
      reg_wr(3'd2, daddr(0));
      saw = 1'b0;
      repeat (20) begin @(negedge clk); if (s_ready) saw = 1'b1; end
      check("R8 stays halted", {31'd0, saw}, 0);
    end
    s_valid = 1'b0; s_last = 1'b0;
    reg_wr(3'd4, 32'd9);
    reg_wr(3'd0, 32'd1);
    reg_rd(3'd0, rd); check("R10 busy", rd, 1);
    reg_wr(3'd5, 32'd7);
    repeat (6) @(negedge clk);
    reg_rd(3'd0, rd); check("R10 done", rd, 0);
    reg_rd(3'd3, rd); check("R10 irq cleared", rd, 0);
    reg_rd(3'd4, rd); check("R10 coal default", rd, 1);
    reg_rd(3'd5, rd); check("R10 write ignored", rd, 0);
    check("R10 irq low", {31'd0, irq}, 0);
    // halt released: engine runs again
    setup_ring(4);
    reg_wr(3'd2, daddr(0));
    push_frame(120, 2);
    repeat (20) @(negedge clk);
    check("R10 runs after reset", mem[daddr(0) + 4], 2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule